// File: doc/BRIEF.md
# Stop-Mode Wake-Up Sequencer

This block decides when a processor core may leave its low-power stop state and fetch its first instruction again. A synchronous stop request parks the core with its clock gated. The sequencer then waits for an asynchronous wake interrupt, which it passes through a two-stage synchronizer. After the wake is seen, it runs a stabilization counter. Where the PLL was powered down during stop, it also waits for PLL lock at the same time as the counter. The core is released, with a one-cycle fetch pulse, only when both of these have finished.

Four configuration inputs decide what the wake-up must wait for:

- **Stop-delay disable:** turns off the long delay.
- **Oscillator keep-alive:** keeps the clock source and the PLL powered during stop.
- **External-clock select:** takes the internal oscillator out of use.
- **PLL enable:** decides whether a PLL relock can apply at all.

The counter is either long (LONG_CYCLES, default 131072, that is 128K cycles) or short (SHORT_CYCLES, default 16). The configuration is captured at the moment the wake is recognized.

Top module: `stop_wake_seq`

## Requirements
- R1: When stop-delay disable is 0 and keep-alive is 0, the wait state lasts LONG_CYCLES cycles. fetch_start is then high in the sample after clock edge 3+LONG_CYCLES, counting from the first edge that sees wake_irq high.
- R2: When stop-delay disable is 1 or keep-alive is 1, the wait lasts SHORT_CYCLES cycles. fetch_start then appears after edge 3+SHORT_CYCLES.
- R3: When PLL enable is 1 and keep-alive is 0, release also requires pll_locked to be seen high during the wait. Wake-up completes at the later of counter completion and lock. Lock presented before edge k is honoured at edge k.
- R4: When PLL enable is 0, pll_locked has no effect and the release time is set by the counter alone.
- R5: When external-clock select is 1, osc_enable is 0 in every state. The choice of delay still follows R1/R2.
- R6: While stopped, core_clock_gate is 1. osc_enable equals (not external-clock) and keep-alive. pll_enable equals PLL enable and keep-alive.
- R7: The wake is recognized only in the stop state, after two synchronizer stages. wake_irq asserted while running produces no fetch_start and no gating.
- R8: fetch_start is a single-cycle pulse. core_clock_gate is 0 from that cycle on. stop_req is ignored from stop entry until fetch_start has been issued.
- R9: Asynchronous reset puts the block in the running state with the counter cleared: core_clock_gate 0, fetch_start 0, osc_enable equal to not external-clock, pll_enable equal to PLL enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req | input | 1 | Request to enter stop, sampled only while running |
| wake_irq | input | 1 | Asynchronous wake interrupt line |
| cfg_delay_off | input | 1 | 1 disables the long stabilization delay |
| cfg_osc_keep | input | 1 | 1 keeps the oscillator and PLL running in stop |
| cfg_ext_clk | input | 1 | 1 selects an external clock instead of the oscillator |
| cfg_pll_on | input | 1 | PLL enable setting |
| pll_locked | input | 1 | PLL lock indication |
| osc_enable | output | 1 | Oscillator power enable |
| pll_enable | output | 1 | PLL power enable |
| core_clock_gate | output | 1 | 1 gates the core clock off |
| fetch_start | output | 1 | One-cycle pulse releasing the first instruction fetch |

## Verification
Completion of the stabilization counter and arrival of PLL lock can fall in the same cycle. The bench provokes this by raising pll_locked so that it is first sampled on the very edge where the short count ends. It expects release on that edge, neither earlier nor one cycle late. Lock is also placed well before and well after counter completion, and the measured wake latency must equal the later of the two.

The bench also lands a stop request inside the wait window. The expected result is that this request neither delays the release nor re-gates the clock afterwards.

// File: rtl/swk_pkg.sv
package swk_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_STOP = 2'd1,
    ST_WAKE = 2'd2,
    ST_REL  = 2'd3
  } swk_state_e;
endpackage

// File: rtl/swk_sync.sv
module swk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d_async};
  end

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/swk_policy.sv
module swk_policy (
  input  logic cfg_delay_off,
  input  logic cfg_osc_keep,
  input  logic cfg_pll_on,
  output logic need_long,
  output logic need_lock
);
  // Clock source kept alive or delay disabled: short count only.
  assign need_long = !cfg_delay_off && !cfg_osc_keep;
  // PLL was powered down in stop only if enabled and not kept alive.
  assign need_lock = cfg_pll_on && !cfg_osc_keep;
endmodule

// File: rtl/swk_delay.sv
module swk_delay #(
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] last,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!en)               cnt_d = '0;
    else if (cnt_q != last) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = en && (cnt_q == last);

  assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    en && $past(en) && $stable(last) |-> cnt_q <= last);
  assert_cnt_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> cnt_q == '0);
endmodule

// File: rtl/stop_wake_seq.sv
module stop_wake_seq #(
  parameter int CNT_W        = 17,
  parameter int LONG_CYCLES  = 131072,
  parameter int SHORT_CYCLES = 16,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_req,
  input  logic wake_irq,
  input  logic cfg_delay_off,
  input  logic cfg_osc_keep,
  input  logic cfg_ext_clk,
  input  logic cfg_pll_on,
  input  logic pll_locked,
  output logic osc_enable,
  output logic pll_enable,
  output logic core_clock_gate,
  output logic fetch_start
);
  import swk_pkg::*;

  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_CYCLES - 1);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_CYCLES - 1);

  swk_state_e state_q, state_d;
  logic wake_s;
  logic need_long_c, need_lock_c;
  logic need_long_q, need_lock_q, lock_seen_q;
  logic dly_done, lock_ok, in_wake, capture;

  swk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(wake_irq), .q_sync(wake_s)
  );

  swk_policy u_policy (
    .cfg_delay_off(cfg_delay_off), .cfg_osc_keep(cfg_osc_keep),
    .cfg_pll_on(cfg_pll_on), .need_long(need_long_c), .need_lock(need_lock_c)
  );

  assign in_wake = (state_q == ST_WAKE);
  assign capture = (state_q == ST_STOP) && wake_s;

  swk_delay #(.CNT_W(CNT_W)) u_delay (
    .clk(clk), .rst_n(rst_n), .en(in_wake),
    .last(need_long_q ? LONG_LAST : SHORT_LAST), .done(dly_done)
  );

  assign lock_ok = !need_lock_q || lock_seen_q || pll_locked;

  // Next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:  if (stop_req)             state_d = ST_STOP;
      ST_STOP: if (wake_s)               state_d = ST_WAKE;
      ST_WAKE: if (dly_done && lock_ok)  state_d = ST_REL;
      ST_REL:                            state_d = ST_RUN;
      default:                           state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RUN;
    else        state_q <= state_d;
  end

  // Wake configuration captured once, when the wake is recognized.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      need_long_q <= 1'b0;
      need_lock_q <= 1'b0;
    end else if (capture) begin
      need_long_q <= need_long_c;
      need_lock_q <= need_lock_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               lock_seen_q <= 1'b0;
    else if (!in_wake)        lock_seen_q <= 1'b0;
    else if (pll_locked)      lock_seen_q <= 1'b1;
  end

  // Outputs
  always_comb begin
    core_clock_gate = (state_q == ST_STOP) || (state_q == ST_WAKE);
    fetch_start     = (state_q == ST_REL);
    if (state_q == ST_STOP) begin
      osc_enable = !cfg_ext_clk && cfg_osc_keep;
      pll_enable = cfg_pll_on && cfg_osc_keep;
    end else begin
      osc_enable = !cfg_ext_clk;
      pll_enable = cfg_pll_on;
    end
  end

  assert_fetch_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_start |=> !fetch_start);
  assert_gate_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_clock_gate) |-> $past(stop_req));
  assert_delay_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fetch_start) |-> $past(dly_done));
  assert_lock_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fetch_start) && need_lock_q |-> lock_seen_q);
  assert_no_wake_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) |=> !in_wake);
  assert_ext_osc_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ext_clk |-> !osc_enable);
endmodule

// File: tb/tb_stop_wake_seq.sv
module tb_stop_wake_seq;
  localparam int CLK_PERIOD = 10;
  localparam int LONG_T  = 200;
  localparam int SHORT_T = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_req = 1'b0, wake_irq = 1'b0;
  logic cfg_delay_off = 1'b0, cfg_osc_keep = 1'b0, cfg_ext_clk = 1'b0, cfg_pll_on = 1'b1;
  logic pll_locked = 1'b0;
  logic osc_enable, pll_enable, core_clock_gate, fetch_start;
  int checks = 0, failures = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stop_wake_seq #(.CNT_W(17), .LONG_CYCLES(LONG_T), .SHORT_CYCLES(SHORT_T)) dut (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .wake_irq(wake_irq),
    .cfg_delay_off(cfg_delay_off), .cfg_osc_keep(cfg_osc_keep),
    .cfg_ext_clk(cfg_ext_clk), .cfg_pll_on(cfg_pll_on), .pll_locked(pll_locked),
    .osc_enable(osc_enable), .pll_enable(pll_enable),
    .core_clock_gate(core_clock_gate), .fetch_start(fetch_start)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic set_cfg(input bit doff, input bit keep, input bit ext, input bit pon);
    cfg_delay_off = doff; cfg_osc_keep = keep; cfg_ext_clk = ext; cfg_pll_on = pon;
  endtask

  // Enter stop and check the stop-state outputs (R6, R5).
  task automatic enter_stop();
    stop_req = 1'b1;
    @(posedge clk); @(negedge clk);
    stop_req = 1'b0;
    pll_locked = 1'b0;
    chk(core_clock_gate == 1'b1, "R6 gate in stop", core_clock_gate, 1);
    chk(osc_enable == (!cfg_ext_clk && cfg_osc_keep), "R6/R5 osc in stop",
        osc_enable, int'(!cfg_ext_clk && cfg_osc_keep));
    chk(pll_enable == (cfg_pll_on && cfg_osc_keep), "R6 pll in stop",
        pll_enable, int'(cfg_pll_on && cfg_osc_keep));
    repeat (3) @(negedge clk);
    chk(core_clock_gate == 1'b1 && fetch_start == 1'b0, "R7 stays stopped without wake",
        core_clock_gate, 1);
  endtask

  // Assert wake, count edges to fetch_start, check pulse and ungating.
  task automatic run_wake(input int exp, input int lock_at, input bit poke_stop, input string req);
    int n = 0;
    bit got = 1'b0;
    wake_irq = 1'b1;
    while (!got && n < 1000) begin
      @(posedge clk); n++;
      @(negedge clk);
      stop_req = (poke_stop && (n == 8 || n == 9));
      if (fetch_start) got = 1'b1;
      else if (n == lock_at) pll_locked = 1'b1;
    end
    stop_req = 1'b0;
    chk(got && n == exp, req, n, exp);
    chk(core_clock_gate == 1'b0, "R8 gate released with fetch", core_clock_gate, 0);
    wake_irq = 1'b0;
    @(negedge clk);
    chk(fetch_start == 1'b0, "R8 fetch pulse one cycle", fetch_start, 0);
    repeat (4) @(negedge clk);
    chk(core_clock_gate == 1'b0, "R8 no re-gate after ignored stop", core_clock_gate, 0);
    pll_locked = 1'b0;
  endtask

  task automatic t_reset();
    set_cfg(0, 0, 0, 1);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(core_clock_gate == 0, "R9 reset gate", core_clock_gate, 0);
    chk(fetch_start == 0, "R9 reset fetch", fetch_start, 0);
    chk(osc_enable == 1 && pll_enable == 1, "R9 reset enables", {osc_enable, pll_enable}, 3);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_wake_in_run();
    wake_irq = 1'b1;
    repeat (10) begin
      @(negedge clk);
      chk(fetch_start == 0 && core_clock_gate == 0, "R7 wake ignored in run",
          {fetch_start, core_clock_gate}, 0);
    end
    wake_irq = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_long_no_pll();
    set_cfg(0, 0, 0, 0); enter_stop();
    run_wake(3 + LONG_T, 1, 0, "R1/R4 long delay, PLL off ignores lock");
  endtask

  task automatic t_keep_short();
    set_cfg(0, 1, 0, 1); enter_stop();
    run_wake(3 + SHORT_T, 0, 0, "R2 keep-alive short, no relock");
  endtask

  task automatic t_lock_late();
    set_cfg(1, 0, 0, 1); enter_stop();
    run_wake(41, 40, 0, "R3 late lock sets release");
  endtask

  task automatic t_lock_early();
    set_cfg(1, 0, 0, 1); enter_stop();
    run_wake(3 + SHORT_T, 5, 0, "R3 early lock, counter sets release");
  endtask

  task automatic t_lock_same_cycle();
    set_cfg(1, 0, 0, 1); enter_stop();
    run_wake(3 + SHORT_T, 2 + SHORT_T, 0, "R3 lock and count end same edge");
  endtask

  task automatic t_long_with_lock();
    set_cfg(0, 0, 0, 1); enter_stop();
    run_wake(3 + LONG_T, 100, 0, "R3 long delay after lock");
    set_cfg(0, 0, 0, 1); enter_stop();
    run_wake(LONG_T + 51, LONG_T + 50, 0, "R3 lock after long delay");
  endtask

  task automatic t_ext_clk();
    set_cfg(0, 0, 1, 0);
    @(negedge clk);
    chk(osc_enable == 0, "R5 ext clk osc off in run", osc_enable, 0);
    enter_stop();
    run_wake(3 + LONG_T, 0, 0, "R5 ext clk long delay");
    set_cfg(1, 0, 1, 0); enter_stop();
    run_wake(3 + SHORT_T, 0, 0, "R5 ext clk delay disabled short");
  endtask

  task automatic t_stop_during_wait();
    set_cfg(1, 0, 0, 0); enter_stop();
    run_wake(3 + SHORT_T, 0, 1, "R8 stop request in wait ignored");
  endtask

  initial begin
    t_reset();
    t_wake_in_run();
    t_long_no_pll();
    t_keep_short();
    t_lock_late();
    t_lock_early();
    t_lock_same_cycle();
    t_long_with_lock();
    t_ext_clk();
    t_stop_during_wait();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule